// File: doc/BRIEF.md
# AGC Error Accumulator

This block turns a stream of quantized baseband I/Q samples into a 12-bit gain-control word. Each sample that arrives with the symbol strobe is reduced to a cheap magnitude estimate. The estimates are summed over a window of 2^k symbols and divided down to an average. At the end of each window the average is taken from a programmable target level, and that difference is added into a saturating accumulator. A large word therefore means the input is weak and the gain in front of the converter must rise.

The block comes out of reset in open-loop mode. In that mode it publishes a programmable hold value at every window end and leaves the accumulator frozen. A host write captures the target, the window exponent, the hold value and the loop mode together. Writing with the closed-loop flag set starts the loop from the accumulator's current value. The new word and a one-cycle update strobe leave the block together.

Top module: `agc_err_acc`

## Requirements
- R1: After reset `agc_word` is 2048 and `agc_upd` is 0. The block starts in open loop with hold value 2048, target 96 and window exponent 11. The accumulator starts at 2048.
- R2: The magnitude estimate of a two's-complement sample pair is max(|I|,|Q|) + floor(min(|I|,|Q|)/2), with |-128| = 128.
- R3: A window holds 2^k strobed samples, where k is the captured `cfg_win_log2` and any value above 11 acts as 11. The average is floor(sum of estimates / 2^k).
- R4: In closed loop, each window end sets accumulator and `agc_word` to accumulator + (target - average), so a weaker input gives a larger word.
- R5: The accumulator saturates at 0 and at 4095 and never wraps.
- R6: In open loop, each window end sets `agc_word` to the captured hold value and leaves the accumulator unchanged. A later switch to closed loop resumes from the frozen value.
- R7: `agc_upd` is high for exactly the one cycle after the clock edge that takes a window's last sample. `agc_word` changes only together with that pulse.
- R8: A cycle with `cfg_wr` high captures target, exponent, hold value and mode (`cfg_closed` 1 = closed, 0 = open). It discards any partial window, and the sample in that cycle is dropped.
- R9: Samples presented while `smp_valid` is low have no effect on the window or the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Symbol strobe qualifying the sample pair |
| smp_i | input | 8 | In-phase sample, two's complement |
| smp_q | input | 8 | Quadrature sample, two's complement |
| cfg_wr | input | 1 | Host write strobe for all settings |
| cfg_closed | input | 1 | Loop mode written on `cfg_wr`: 1 closed, 0 open |
| cfg_target | input | 8 | Target average magnitude |
| cfg_win_log2 | input | 4 | Window exponent k (window = 2^k symbols) |
| cfg_hold | input | 12 | Word published in open loop |
| agc_word | output | 12 | Published gain-control word |
| agc_upd | output | 1 | One-cycle pulse marking a new word |

## Verification
A table of sample pairs is used with one-symbol windows. The pairs cover each quadrant, I dominant against Q dominant, the -128 corner, zero, and equal magnitudes. This separates a wrong absolute value, a swapped max/min or a missing halving, and it drives the error positive and negative. Multi-symbol windows with unstrobed samples in between show that averaging uses only strobed data and truncates. The 2048-symbol windows, at reset and with an exponent of 15, check the full window and the clamp. Long runs of maximal positive and negative error pin the accumulator at both rails. A write in the middle of a window shows that the partial sum is thrown away.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic {
    LOOP_OPEN   = 1'b0,
    LOOP_CLOSED = 1'b1
  } loop_mode_e;

  localparam int AGC_SAMP_W   = 8;
  localparam int AGC_WORD_W   = 12;
  localparam int AGC_LOGW_MAX = 11;
  localparam int AGC_KW       = 4;
endpackage

// File: rtl/agc_magnitude.sv
module agc_magnitude #(
  parameter int SAMP_W = 8
) (
  input  logic signed [SAMP_W-1:0] in_i,
  input  logic signed [SAMP_W-1:0] in_q,
  output logic        [SAMP_W-1:0] mag
);
  // |x| needs one extra bit of headroom only for the most negative code
  function automatic logic [SAMP_W-1:0] abs_val(input logic signed [SAMP_W-1:0] x);
    logic signed [SAMP_W:0] xe;
    logic signed [SAMP_W:0] ax;
    xe = {x[SAMP_W-1], x};
    ax = (xe < 0) ? -xe : xe;
    return ax[SAMP_W-1:0];
  endfunction

  // max + min/2 : bounded by 1.5 * 2^(SAMP_W-1), so it fits SAMP_W bits
  function automatic logic [SAMP_W-1:0] mag_est(input logic [SAMP_W-1:0] a,
                                                input logic [SAMP_W-1:0] b);
    logic [SAMP_W-1:0] hi;
    logic [SAMP_W-1:0] lo;
    hi = (a > b) ? a : b;
    lo = (a > b) ? b : a;
    return hi + (lo >> 1);
  endfunction

  logic [SAMP_W-1:0] abs_i;
  logic [SAMP_W-1:0] abs_q;

  always_comb begin
    abs_i = abs_val(in_i);
    abs_q = abs_val(in_q);
    mag   = mag_est(abs_i, abs_q);
  end
endmodule

// File: rtl/agc_window_avg.sv
module agc_window_avg #(
  parameter int MAG_W    = 8,
  parameter int LOGW_MAX = 11,
  parameter int KW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             valid,
  input  logic [MAG_W-1:0] mag,
  input  logic [KW-1:0]    win_log2,
  output logic             win_done,
  output logic [MAG_W-1:0] avg
);
  localparam int CNT_W = LOGW_MAX;
  localparam int SUM_W = MAG_W + LOGW_MAX;

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sum;
  logic [KW-1:0]    k_eff;
  logic [CNT_W:0]   full_len;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;
  logic [SUM_W-1:0] sum_next;

  always_comb begin
    k_eff    = (win_log2 > KW'(LOGW_MAX)) ? KW'(LOGW_MAX) : win_log2;
    full_len = (CNT_W+1)'(1) << k_eff;
    last_idx = CNT_W'(full_len - (CNT_W+1)'(1));
    at_last  = (cnt == last_idx);
    sum_next = sum + SUM_W'(mag);
    avg      = MAG_W'(sum_next >> k_eff);
    win_done = valid && !restart && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sum <= '0;
    end else if (restart) begin
      cnt <= '0;
      sum <= '0;
    end else if (valid) begin
      if (at_last) begin
        cnt <= '0;
        sum <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
        sum <= sum_next;
      end
    end
  end

  // R3: the symbol index never passes the window currently configured
  a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

  // R8: a host write empties the window
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && sum == '0));

  // R9: without a strobe or write the window state holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !restart) |=> ($stable(cnt) && $stable(sum)));
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator #(
  parameter int WORD_W = 12,
  parameter int ERR_W  = 9,
  parameter int ACC_RST = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic signed [ERR_W-1:0] err,
  output logic [WORD_W-1:0]       acc,
  output logic [WORD_W-1:0]       acc_next
);
  localparam int EXT_W = WORD_W + 2;
  localparam logic [WORD_W-1:0] ACC_MAX = '1;

  // clamps to [0, 2^WORD_W-1] instead of wrapping
  function automatic logic [WORD_W-1:0] sat_add(input logic [WORD_W-1:0] a,
                                                input logic signed [ERR_W-1:0] e);
    logic signed [EXT_W-1:0] t;
    t = $signed({2'b00, a}) + EXT_W'(e);
    if (t < 0)
      return '0;
    else if (t > $signed({2'b00, ACC_MAX}))
      return ACC_MAX;
    else
      return t[WORD_W-1:0];
  endfunction

  always_comb acc_next = sat_add(acc, err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= WORD_W'(ACC_RST);
    else if (step_en)   acc <= acc_next;
  end

  // R5: a positive error never makes the value smaller (no wrap at the top)
  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && err > 0) |=> acc >= $past(acc));

  // R5: a negative error never makes the value larger (no wrap at zero)
  a_r5_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && err < 0) |=> acc <= $past(acc));

  // R6: with no closed-loop step the accumulator is frozen
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc));
endmodule

// File: rtl/agc_err_acc.sv
module agc_err_acc
  import agc_pkg::*;
#(
  parameter int SAMP_W    = AGC_SAMP_W,
  parameter int WORD_W    = AGC_WORD_W,
  parameter int LOGW_MAX  = AGC_LOGW_MAX,
  parameter int KW        = AGC_KW,
  parameter int HOLD_RST  = 2048,
  parameter int TGT_RST   = 96
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_i,
  input  logic signed [SAMP_W-1:0] smp_q,
  input  logic                     cfg_wr,
  input  logic                     cfg_closed,
  input  logic [SAMP_W-1:0]        cfg_target,
  input  logic [KW-1:0]            cfg_win_log2,
  input  logic [WORD_W-1:0]        cfg_hold,
  output logic [WORD_W-1:0]        agc_word,
  output logic                     agc_upd
);
  localparam int MAG_W = SAMP_W;
  localparam int ERR_W = MAG_W + 1;

  loop_mode_e          mode_q;
  logic [MAG_W-1:0]    target_q;
  logic [KW-1:0]       win_log2_q;
  logic [WORD_W-1:0]   hold_q;

  logic [MAG_W-1:0]        mag;
  logic [MAG_W-1:0]        win_avg;
  logic                    win_done;
  logic signed [ERR_W-1:0] loop_err;
  logic                    step_en;
  logic [WORD_W-1:0]       acc;
  logic [WORD_W-1:0]       acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= LOOP_OPEN;
      target_q   <= MAG_W'(TGT_RST);
      win_log2_q <= KW'(LOGW_MAX);
      hold_q     <= WORD_W'(HOLD_RST);
    end else if (cfg_wr) begin
      mode_q     <= cfg_closed ? LOOP_CLOSED : LOOP_OPEN;
      target_q   <= cfg_target;
      win_log2_q <= cfg_win_log2;
      hold_q     <= cfg_hold;
    end
  end

  agc_magnitude #(.SAMP_W(SAMP_W)) u_mag (
    .in_i (smp_i),
    .in_q (smp_q),
    .mag  (mag)
  );

  agc_window_avg #(.MAG_W(MAG_W), .LOGW_MAX(LOGW_MAX), .KW(KW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_wr),
    .valid    (smp_valid),
    .mag      (mag),
    .win_log2 (win_log2_q),
    .win_done (win_done),
    .avg      (win_avg)
  );

  always_comb begin
    loop_err = $signed({1'b0, target_q}) - $signed({1'b0, win_avg});
    step_en  = win_done && (mode_q == LOOP_CLOSED);
  end

  agc_integrator #(.WORD_W(WORD_W), .ERR_W(ERR_W), .ACC_RST(HOLD_RST)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .err      (loop_err),
    .acc      (acc),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agc_word <= WORD_W'(HOLD_RST);
      agc_upd  <= 1'b0;
    end else begin
      agc_upd <= win_done;
      if (win_done)
        agc_word <= (mode_q == LOOP_CLOSED) ? acc_next : hold_q;
    end
  end

  // R7: the word only moves together with the strobe
  a_r7_word_only_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_upd |-> $stable(agc_word));

  // R7/R9: a strobe follows an accepted sample, never a write cycle
  a_r7_upd_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    agc_upd |-> $past(smp_valid && !cfg_wr));

  // R4: a closed-loop update publishes the integrator's new value
  a_r4_word_is_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_upd && $past(mode_q) == LOOP_CLOSED) |-> agc_word == acc);

  // R6: an open-loop update publishes the hold value
  a_r6_word_is_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_upd && $past(mode_q) == LOOP_OPEN) |-> agc_word == $past(hold_q));
endmodule

// File: tb/test_agc_err_acc.sv
module test_agc_err_acc;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [7:0] smp_i = '0;
  logic signed [7:0] smp_q = '0;
  logic              cfg_wr = 1'b0;
  logic              cfg_closed = 1'b0;
  logic [7:0]        cfg_target = '0;
  logic [3:0]        cfg_win_log2 = '0;
  logic [11:0]       cfg_hold = '0;
  logic [11:0]       agc_word;
  logic              agc_upd;

  always #2.5 clk = ~clk;

  agc_err_acc i_agc_err_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .cfg_wr(cfg_wr), .cfg_closed(cfg_closed), .cfg_target(cfg_target),
    .cfg_win_log2(cfg_win_log2), .cfg_hold(cfg_hold),
    .agc_word(agc_word), .agc_upd(agc_upd)
  );

  // {I, Q, expected magnitude}
  localparam logic [23:0] VEC [0:7] = '{
    24'h0A040C, 24'hEC0617, 24'h05E220, 24'h8080C0,
    24'h7F007F, 24'h000000, 24'hF9F90A, 24'h409C84
  };

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  int m_acc = 2048, m_word = 2048, m_hold = 2048, m_tgt = 96, m_k = 11;
  int m_cnt = 0, m_sum = 0;
  bit m_closed = 1'b0;
  bit m_upd = 1'b0;

  function automatic int ref_mag(input int i, input int q);
    int ai, aq, hi, lo;
    ai = (i < 0) ? -i : i;
    aq = (q < 0) ? -q : q;
    if (ai >= aq) begin hi = ai; lo = aq; end
    else begin hi = aq; lo = ai; end
    return hi + lo / 2;
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (agc_upd !== m_upd || agc_word !== 12'(m_word)) begin
      n_fail++;
      $display("FAIL %s: upd=%0b word=%0d expected upd=%0b word=%0d",
               tag, agc_upd, agc_word, m_upd, m_word);
    end
  endtask

  task automatic step(input bit v, input int i, input int q, input int m, input string tag);
    int win, s, avg;
    @(negedge clk);
    cfg_wr = 1'b0;
    smp_valid = v;
    smp_i = 8'(i);
    smp_q = 8'(q);
    @(posedge clk);
    #1;
    m_upd = 1'b0;
    if (v) begin
      win = 1 << ((m_k > 11) ? 11 : m_k);
      s = m_sum + m;
      if (m_cnt == win - 1) begin
        avg = s / win;
        if (m_closed) begin
          m_acc = m_acc + m_tgt - avg;
          if (m_acc < 0) m_acc = 0;
          if (m_acc > 4095) m_acc = 4095;
          m_word = m_acc;
        end else begin
          m_word = m_hold;
        end
        m_upd = 1'b1;
        m_cnt = 0;
        m_sum = 0;
      end else begin
        m_cnt++;
        m_sum = s;
      end
    end
    compare(tag);
  endtask

  task automatic configure(input bit closed, input int tgt, input int k, input int hold,
                           input string tag);
    @(negedge clk);
    cfg_wr = 1'b1;
    smp_valid = 1'b1;          // R8: sample in a write cycle is dropped
    smp_i = 8'sd100;
    smp_q = 8'sd100;
    cfg_closed = closed;
    cfg_target = 8'(tgt);
    cfg_win_log2 = 4'(k);
    cfg_hold = 12'(hold);
    @(posedge clk);
    #1;
    m_closed = closed; m_tgt = tgt; m_k = k; m_hold = hold;
    m_cnt = 0; m_sum = 0; m_upd = 1'b0;
    compare(tag);
  endtask

  task automatic vec_step(input int idx, input string tag);
    int i, q;
    i = int'($signed(VEC[idx][23:16]));
    q = int'($signed(VEC[idx][15:8]));
    n_checks++;
    if (ref_mag(i, q) != int'(VEC[idx][7:0])) begin
      n_fail++;
      $display("FAIL R2: table magnitude %0d expected %0d", VEC[idx][7:0], ref_mag(i, q));
    end
    step(1'b1, i, q, int'(VEC[idx][7:0]), tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion before 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (agc_word !== 12'd2048 || agc_upd !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: word=%0d upd=%0b in reset expected 2048 0", agc_word, agc_upd);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    m_upd = 1'b0;
    compare("R1 after release");

    // default open loop, 2048-symbol window (R1, R3, R6)
    for (int n = 0; n < 2048; n++) step(1'b1, 3, -3, ref_mag(3, -3), "R3 R6 default window");
    step(1'b0, 100, 100, 0, "R9 unstrobed sample");
    step(1'b0, -128, 5, 0, "R7 no second pulse");

    // open loop with new hold value (R6, R8)
    configure(1'b0, 64, 0, 1234, "R8 open write");
    step(1'b1, 50, 50, ref_mag(50, 50), "R6 hold published");
    step(1'b1, -1, 2, ref_mag(-1, 2), "R6 hold again");

    // closed loop, one-symbol windows, vector table (R2, R4, R6 frozen start)
    configure(1'b1, 64, 0, 1234, "R8 closed write");
    for (int n = 0; n < 8; n++) vec_step(n, "R2 R4 table");

    // four-symbol window with gaps (R3, R9, R7)
    configure(1'b1, 50, 2, 0, "R8 k=2");
    vec_step(0, "R3 window 1/4");
    step(1'b0, -128, -128, 0, "R9 gap");
    vec_step(1, "R3 window 2/4");
    vec_step(2, "R3 window 3/4");
    step(1'b0, 127, 127, 0, "R9 gap");
    vec_step(6, "R3 window end");
    step(1'b0, 0, 0, 0, "R7 single pulse");

    // restart mid-window (R8)
    vec_step(3, "R8 partial 1");
    vec_step(4, "R8 partial 2");
    configure(1'b1, 50, 2, 0, "R8 rewrite");
    vec_step(5, "R8 after restart 1");
    vec_step(7, "R8 after restart 2");
    vec_step(0, "R8 after restart 3");
    vec_step(3, "R8 window end");

    // saturation at both rails (R5)
    configure(1'b1, 255, 0, 0, "R5 high setup");
    for (int n = 0; n < 14; n++) step(1'b1, 0, 0, 0, "R5 upper rail");
    configure(1'b1, 0, 0, 0, "R5 low setup");
    for (int n = 0; n < 25; n++) step(1'b1, -128, -128, 192, "R5 lower rail");

    // exponent above the maximum acts as 11 (R3)
    configure(1'b1, 20, 15, 0, "R3 clamp setup");
    for (int n = 0; n < 2048; n++) step(1'b1, 0, 0, 0, "R3 clamped window");
    step(1'b0, 0, 0, 0, "R7 after clamp");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule